// File: doc/BRIEF.md
# Power-Management Event Router

This block keeps one status flag and one control flag for each of six power-management events: a power button, a real-time-clock alarm, a timer overflow, a global-lock event, a PCI Express wake and a clockless USB wake. It also keeps a wake flag. Single-cycle hardware pulses set the status flags. A small register port reads both registers, clears status flags by writing ones, and reads and writes the control flags.

While the system is running, each pending event with its control flag set drives a level interrupt. A shared `sci_en` input picks the interrupt type: the system-management interrupt (SMI) or the system-control interrupt (SCI). While the system is asleep, both interrupts are held low. Qualified pending events instead set the wake flag, and the wake flag requests a return to the ON state. The power button always wakes the system. The PCI Express wake is controlled by a disable flag, the USB wake by an enable flag, and the timer and global events never wake the system.

The flags belong to three reset domains: resume well, platform and RTC well. Each domain has its own asynchronous active-low reset, released through a synchroniser. Two more rules apply. A power-button override or a thermal trip clears the RTC alarm enable. A power-return pulse sets the wake flag only when an after-power-loss option input is high.

Top module: `pm_evt_router`

## Requirements
- R1: While `sleeping`=0, each of the timer, power-button and RTC sources (status AND its enable) gives no interrupt when its enable is 0. With the enable at 1 it raises `smi` when `sci_en`=0 and `sci` when `sci_en`=1. Both outputs are combinational levels that stay high while any such pair is set.
- R2: While `sleeping`=0, `sci` is high whenever the global status and the global enable are both set, whatever `sci_en` is.
- R3: While `sleeping`=1, `smi` and `sci` are low. The wake status is set one cycle after any of these holds: power-button status; RTC status with RTC enable; PCIe status with PCIe wake-disable at 0; USB status with USB wake-enable at 1. Timer and global status never set it.
- R4: `go_on` is high exactly while the wake status is set and `sleeping`=1.
- R5: An event pulse sets its status bit at the next clock edge, whatever its enable is. A hardware set wins over a same-cycle write-one-to-clear of that bit.
- R6: A write to address 0 clears each status bit written with 1 and leaves bits written with 0 unchanged. A write to address 1 never changes any status bit.
- R7: Address 0 reads the status bits at [6:0], in the order timer, global, power button, RTC, PCIe, USB, wake. Address 1 reads and writes the controls at [5:0], in the order timer enable, global enable, power-button enable, RTC enable, PCIe wake-disable, USB wake-enable. All other bits and addresses read 0 and ignore writes. `reg_rdata` follows `reg_addr` combinationally.
- R8: A `pwrbtn_override` or `thermal_trip` pulse clears the RTC enable at the next edge, and wins over a same-cycle software write of 1.
- R9: A `pwr_return` pulse sets the wake status when `after_loss_wake`=1. When `after_loss_wake`=0 it leaves the wake status clear.
- R10: `rst_plat_n` clears only the timer and global status and enable bits. `rst_rtc_n` clears only the RTC status and RTC enable. `rst_resume_n` clears the power-button, PCIe, USB and wake status bits and the power-button enable, PCIe disable and USB enable. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume_n | input | 1 | Resume-well reset, async active-low |
| rst_plat_n | input | 1 | Platform reset, async active-low |
| rst_rtc_n | input | 1 | RTC-well reset, async active-low |
| sci_en | input | 1 | Shared select: 1 routes to SCI, 0 to SMI |
| sleeping | input | 1 | System is in a sleep state |
| after_loss_wake | input | 1 | After-power-loss wake option |
| pwr_return | input | 1 | Pulse: power has returned |
| ev_pwrbtn | input | 1 | Pulse: power button pressed |
| ev_rtc | input | 1 | Pulse: RTC alarm |
| ev_tmr | input | 1 | Pulse: timer overflow |
| ev_glb | input | 1 | Pulse: global-lock event |
| ev_pcie | input | 1 | Pulse: PCI Express wake |
| ev_usb | input | 1 | Pulse: clockless USB wake |
| pwrbtn_override | input | 1 | Pulse: power-button override |
| thermal_trip | input | 1 | Pulse: CPU thermal trip |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| smi | output | 1 | SMI request level |
| sci | output | 1 | SCI request level |
| go_on | output | 1 | Request to move to the ON state |

## Verification
The bench tests the wake qualifiers in both directions. It checks that a timer or global event, a disabled USB wake and a disabled PCIe wake leave the wake flag clear. A design that mixed up the polarity of the disable and enable controls would wake on the wrong source. It also checks that a power-button press wakes the system even with its enable clear. The bench makes a set and a clear of the same status bit land in one cycle, and makes a thermal trip coincide with a software write of the RTC enable. Both cases expose a wrong priority. The bench then pulses each reset domain alone and reads back both registers. A design that shared a reset between domains would lose bits that must survive.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int NSTS = 7;
  localparam int NEN  = 6;

  localparam int IDX_TMR    = 0;
  localparam int IDX_GLB    = 1;
  localparam int IDX_PWRBTN = 2;
  localparam int IDX_RTC    = 3;
  localparam int IDX_PCIE   = 4;
  localparam int IDX_USB    = 5;
  localparam int IDX_WAKE   = 6;

  typedef enum logic [1:0] {
    DOM_RESUME = 2'd0,
    DOM_PLAT   = 2'd1,
    DOM_RTC    = 2'd2
  } rst_dom_e;

  localparam int NDOM = 3;

  // Reset domain of a status bit or of the control bit at the same index
  function automatic rst_dom_e dom_of(input int idx);
    if (idx == IDX_TMR || idx == IDX_GLB) return DOM_PLAT;
    else if (idx == IDX_RTC)              return DOM_RTC;
    else                                  return DOM_RESUME;
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/pm_reg_cell.sv
module pm_reg_cell #(
  parameter bit IS_W1C = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_d,
  output logic q
);
  logic q_d;
  logic q_en;

  generate
    if (IS_W1C) begin : g_w1c
      // hardware set has priority over a software clear
      always_comb begin
        q_en = hw_set | (sw_we & sw_d);
        q_d  = hw_set;
      end
    end else begin : g_rw
      // hardware clear has priority over a software write
      always_comb begin
        q_en = hw_clr | sw_we;
        q_d  = hw_clr ? 1'b0 : sw_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/pm_route.sv
module pm_route
  import pm_evt_pkg::*;
(
  input  logic [NSTS-2:0] sts,
  input  logic [NEN-1:0]  ctl,
  input  logic            sci_en,
  input  logic            sleeping,
  output logic            smi,
  output logic            sci,
  output logic            wake_hit
);
  logic routed;
  logic glb_hit;
  logic wake_any;

  always_comb begin
    routed   = (sts[IDX_TMR] & ctl[IDX_TMR]) |
               (sts[IDX_PWRBTN] & ctl[IDX_PWRBTN]) |
               (sts[IDX_RTC] & ctl[IDX_RTC]);
    glb_hit  = sts[IDX_GLB] & ctl[IDX_GLB];
    wake_any = sts[IDX_PWRBTN] |
               (sts[IDX_RTC] & ctl[IDX_RTC]) |
               (sts[IDX_PCIE] & ~ctl[IDX_PCIE]) |
               (sts[IDX_USB] & ctl[IDX_USB]);
    smi      = ~sleeping & routed & ~sci_en;
    sci      = ~sleeping & ((routed & sci_en) | glb_hit);
    wake_hit = sleeping & wake_any;
  end
endmodule

// File: rtl/pm_evt_router.sv
module pm_evt_router
  import pm_evt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_resume_n,
  input  logic              rst_plat_n,
  input  logic              rst_rtc_n,
  input  logic              sci_en,
  input  logic              sleeping,
  input  logic              after_loss_wake,
  input  logic              pwr_return,
  input  logic              ev_pwrbtn,
  input  logic              ev_rtc,
  input  logic              ev_tmr,
  input  logic              ev_glb,
  input  logic              ev_pcie,
  input  logic              ev_usb,
  input  logic              pwrbtn_override,
  input  logic              thermal_trip,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              smi,
  output logic              sci,
  output logic              go_on
);
  localparam logic [ADDR_W-1:0] ADDR_STS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(1);

  logic [NDOM-1:0] dom_arst_n;
  logic [NDOM-1:0] dom_rst_n;
  logic [NSTS-1:0] sts_q;
  logic [NSTS-1:0] sts_set;
  logic [NEN-1:0]  ctl_q;
  logic [NEN-1:0]  ctl_clr;
  logic            sts_we;
  logic            ctl_we;
  logic            wake_hit;

  assign dom_arst_n[DOM_RESUME] = rst_resume_n;
  assign dom_arst_n[DOM_PLAT]   = rst_plat_n;
  assign dom_arst_n[DOM_RTC]    = rst_rtc_n;

  generate
    for (genvar d = 0; d < NDOM; d++) begin : g_sync
      pm_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .arst_n (dom_arst_n[d]),
        .srst_n (dom_rst_n[d])
      );
    end
  endgenerate

  assign sts_we = reg_we && (reg_addr == ADDR_STS);
  assign ctl_we = reg_we && (reg_addr == ADDR_CTL);

  always_comb begin
    sts_set              = '0;
    sts_set[IDX_TMR]     = ev_tmr;
    sts_set[IDX_GLB]     = ev_glb;
    sts_set[IDX_PWRBTN]  = ev_pwrbtn;
    sts_set[IDX_RTC]     = ev_rtc;
    sts_set[IDX_PCIE]    = ev_pcie;
    sts_set[IDX_USB]     = ev_usb;
    sts_set[IDX_WAKE]    = wake_hit | (pwr_return & after_loss_wake);
    ctl_clr              = '0;
    ctl_clr[IDX_RTC]     = pwrbtn_override | thermal_trip;
  end

  generate
    for (genvar i = 0; i < NSTS; i++) begin : g_sts
      localparam rst_dom_e DOM = dom_of(i);
      pm_reg_cell #(.IS_W1C(1'b1)) i_cell (
        .clk    (clk),
        .rst_n  (dom_rst_n[DOM]),
        .hw_set (sts_set[i]),
        .hw_clr (1'b0),
        .sw_we  (sts_we),
        .sw_d   (reg_wdata[i]),
        .q      (sts_q[i])
      );
    end
    for (genvar i = 0; i < NEN; i++) begin : g_ctl
      localparam rst_dom_e DOM = dom_of(i);
      pm_reg_cell #(.IS_W1C(1'b0)) i_cell (
        .clk    (clk),
        .rst_n  (dom_rst_n[DOM]),
        .hw_set (1'b0),
        .hw_clr (ctl_clr[i]),
        .sw_we  (ctl_we),
        .sw_d   (reg_wdata[i]),
        .q      (ctl_q[i])
      );
    end
  endgenerate

  pm_route i_route (
    .sts      (sts_q[NSTS-2:0]),
    .ctl      (ctl_q),
    .sci_en   (sci_en),
    .sleeping (sleeping),
    .smi      (smi),
    .sci      (sci),
    .wake_hit (wake_hit)
  );

  assign go_on = sts_q[IDX_WAKE] & sleeping;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STS)      reg_rdata[NSTS-1:0] = sts_q;
    else if (reg_addr == ADDR_CTL) reg_rdata[NEN-1:0]  = ctl_q;
  end
endmodule

// File: rtl/pm_evt_router_chk.sv
module pm_evt_router_chk
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic [NDOM-1:0]   dom_rst_n,
  input logic              sleeping,
  input logic              smi,
  input logic              sci,
  input logic              go_on,
  input logic              ev_pwrbtn,
  input logic              ev_rtc,
  input logic              ev_tmr,
  input logic              ev_glb,
  input logic              ev_pcie,
  input logic              ev_usb,
  input logic              pwr_return,
  input logic              pwrbtn_override,
  input logic              thermal_trip,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NSTS-1:0]   sts_q,
  input logic [NEN-1:0]    ctl_q
);
  logic all_up;
  logic no_ev;
  assign all_up = &dom_rst_n;
  assign no_ev  = !(ev_pwrbtn || ev_rtc || ev_tmr || ev_glb || ev_pcie || ev_usb);

  AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!all_up)
    sleeping |-> (!smi && !sci)); // R3

  AST_GO_ON_ASLEEP: assert property (@(posedge clk) disable iff (!all_up)
    go_on |-> (sleeping && sts_q[IDX_WAKE])); // R4

  AST_PWRBTN_SETS: assert property (@(posedge clk) disable iff (!all_up)
    ev_pwrbtn |=> sts_q[IDX_PWRBTN]); // R5

  AST_RTC_EN_CLEARED: assert property (@(posedge clk) disable iff (!all_up)
    (pwrbtn_override || thermal_trip) |=> !ctl_q[IDX_RTC]); // R8

  AST_CTL_WR_KEEPS_STS: assert property (@(posedge clk) disable iff (!all_up)
    (reg_we && reg_addr == ADDR_W'(1) && no_ev && !sleeping && !pwr_return)
      |=> $stable(sts_q)); // R6

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!all_up)
    $rose(sts_q[IDX_WAKE]) |-> ($past(sleeping) || $past(pwr_return))); // R9
endmodule

bind pm_evt_router pm_evt_router_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk             (clk),
  .dom_rst_n       (dom_rst_n),
  .sleeping        (sleeping),
  .smi             (smi),
  .sci             (sci),
  .go_on           (go_on),
  .ev_pwrbtn       (ev_pwrbtn),
  .ev_rtc          (ev_rtc),
  .ev_tmr          (ev_tmr),
  .ev_glb          (ev_glb),
  .ev_pcie         (ev_pcie),
  .ev_usb          (ev_usb),
  .pwr_return      (pwr_return),
  .pwrbtn_override (pwrbtn_override),
  .thermal_trip    (thermal_trip),
  .reg_we          (reg_we),
  .reg_addr        (reg_addr),
  .sts_q           (sts_q),
  .ctl_q           (ctl_q)
);

// File: tb/test_pm_evt_router.sv
`timescale 1ns/1ps
module test_pm_evt_router;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_resume_n, rst_plat_n, rst_rtc_n;
  logic sci_en, sleeping, after_loss_wake, pwr_return;
  logic ev_pwrbtn, ev_rtc, ev_tmr, ev_glb, ev_pcie, ev_usb;
  logic pwrbtn_override, thermal_trip;
  logic [AW-1:0] reg_addr;
  logic reg_we;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic smi, sci, go_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_evt_router i_pm_evt_router (
    .clk(clk), .rst_resume_n(rst_resume_n), .rst_plat_n(rst_plat_n),
    .rst_rtc_n(rst_rtc_n), .sci_en(sci_en), .sleeping(sleeping),
    .after_loss_wake(after_loss_wake), .pwr_return(pwr_return),
    .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .ev_tmr(ev_tmr), .ev_glb(ev_glb),
    .ev_pcie(ev_pcie), .ev_usb(ev_usb), .pwrbtn_override(pwrbtn_override),
    .thermal_trip(thermal_trip), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi(smi), .sci(sci),
    .go_on(go_on)
  );

  // behavioural reference: status bits s_*, controls c_*
  bit s_tmr, s_glb, s_pb, s_rtc, s_pcie, s_usb, s_wake;
  bit c_tmr, c_glb, c_pb, c_rtc, c_pdis, c_usb;

  always @(posedge clk) begin
    bit n_tmr, n_glb, n_pb, n_rtc, n_pcie, n_usb, n_wake;
    bit wake_cond;
    n_tmr = s_tmr; n_glb = s_glb; n_pb = s_pb; n_rtc = s_rtc;
    n_pcie = s_pcie; n_usb = s_usb; n_wake = s_wake;
    wake_cond = sleeping && (s_pb || (s_rtc && c_rtc) || (s_pcie && !c_pdis) || (s_usb && c_usb));
    if (reg_we && reg_addr == 0) begin
      if (reg_wdata[0]) n_tmr = 0;
      if (reg_wdata[1]) n_glb = 0;
      if (reg_wdata[2]) n_pb = 0;
      if (reg_wdata[3]) n_rtc = 0;
      if (reg_wdata[4]) n_pcie = 0;
      if (reg_wdata[5]) n_usb = 0;
      if (reg_wdata[6]) n_wake = 0;
    end
    if (ev_tmr) n_tmr = 1;
    if (ev_glb) n_glb = 1;
    if (ev_pwrbtn) n_pb = 1;
    if (ev_rtc) n_rtc = 1;
    if (ev_pcie) n_pcie = 1;
    if (ev_usb) n_usb = 1;
    if (wake_cond || (pwr_return && after_loss_wake)) n_wake = 1;
    if (reg_we && reg_addr == 1) begin
      c_tmr = reg_wdata[0]; c_glb = reg_wdata[1]; c_pb = reg_wdata[2];
      c_rtc = reg_wdata[3]; c_pdis = reg_wdata[4]; c_usb = reg_wdata[5];
    end
    if (pwrbtn_override || thermal_trip) c_rtc = 0;
    s_tmr = n_tmr; s_glb = n_glb; s_pb = n_pb; s_rtc = n_rtc;
    s_pcie = n_pcie; s_usb = n_usb; s_wake = n_wake;
    if (!rst_plat_n) begin s_tmr = 0; s_glb = 0; c_tmr = 0; c_glb = 0; end
    if (!rst_rtc_n) begin s_rtc = 0; c_rtc = 0; end
    if (!rst_resume_n) begin
      s_pb = 0; s_pcie = 0; s_usb = 0; s_wake = 0; c_pb = 0; c_pdis = 0; c_usb = 0;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    bit routed, e_smi, e_sci, e_go;
    logic [DW-1:0] e_rd;
    if (rst_resume_n && rst_plat_n && rst_rtc_n && !done) begin
      routed = (s_tmr && c_tmr) || (s_pb && c_pb) || (s_rtc && c_rtc);
      e_smi = !sleeping && routed && !sci_en;
      e_sci = !sleeping && ((routed && sci_en) || (s_glb && c_glb));
      e_go  = s_wake && sleeping;
      e_rd  = '0;
      if (reg_addr == 0) e_rd[6:0] = {s_wake, s_usb, s_pcie, s_rtc, s_pb, s_glb, s_tmr};
      else if (reg_addr == 1) e_rd[5:0] = {c_usb, c_pdis, c_rtc, c_pb, c_glb, c_tmr};
      chk("R1 smi vs model", {31'b0, smi}, {31'b0, e_smi});
      chk("R2 sci vs model", {31'b0, sci}, {31'b0, e_sci});
      chk("R4 go_on vs model", {31'b0, go_on}, {31'b0, e_go});
      chk("R7 rdata vs model", reg_rdata, e_rd);
    end
  end

  task automatic step();
    @(negedge clk); #1;
    ev_pwrbtn = 0; ev_rtc = 0; ev_tmr = 0; ev_glb = 0; ev_pcie = 0; ev_usb = 0;
    pwr_return = 0; pwrbtn_override = 0; thermal_trip = 0; reg_we = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(); reg_addr = a; reg_wdata = d; reg_we = 1;
    step();
  endtask

  task automatic ev(input logic [5:0] m);
    step();
    ev_tmr = m[0]; ev_glb = m[1]; ev_pwrbtn = m[2]; ev_rtc = m[3]; ev_pcie = m[4]; ev_usb = m[5];
    step();
  endtask

  task automatic rchk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    step(); reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_resume_n = 0; rst_plat_n = 0; rst_rtc_n = 0;
    sci_en = 0; sleeping = 0; after_loss_wake = 0; pwr_return = 0;
    ev_pwrbtn = 0; ev_rtc = 0; ev_tmr = 0; ev_glb = 0; ev_pcie = 0; ev_usb = 0;
    pwrbtn_override = 0; thermal_trip = 0; reg_addr = 0; reg_we = 0; reg_wdata = 0;
    idle(3);
    rst_resume_n = 1; rst_plat_n = 1; rst_rtc_n = 1;
    idle(5);
    rchk(0, 32'h0, "R10 reset status");
    rchk(1, 32'h0, "R10 reset controls");

    // R1 timer routing
    wr(1, 32'h01);
    ev(6'h01);
    step(); sci_en = 0; @(negedge clk);
    chk("R1 tmr smi", {31'b0, smi}, 32'h1);
    step(); sci_en = 1; @(negedge clk);
    chk("R1 tmr sci", {31'b0, sci}, 32'h1);
    chk("R1 tmr no smi", {31'b0, smi}, 32'h0);
    wr(0, 32'h01);
    @(negedge clk);
    chk("R6 w1c clears sci", {31'b0, sci}, 32'h0);
    // enable 0: no interrupt
    wr(1, 32'h00);
    ev(6'h0C);
    @(negedge clk);
    chk("R1 disabled no sci", {31'b0, sci}, 32'h0);
    rchk(0, 32'h0C, "R5 status set with enable clear");
    // R5 set wins over same-cycle clear
    step(); ev_pwrbtn = 1; reg_addr = 0; reg_wdata = 32'h04; reg_we = 1;
    step();
    rchk(0, 32'h0C, "R5 set beats clear");
    // R6 writes of 0 and control writes leave status
    wr(0, 32'h0);
    wr(1, 32'h3F);
    rchk(0, 32'h0C, "R6 status unchanged");
    rchk(1, 32'h3F, "R7 control readback");
    rchk(2, 32'h0, "R7 unused address");
    wr(3, 32'hFFFF_FFFF);
    rchk(1, 32'h3F, "R7 ignored address write");
    // R2 global sci with sci_en=0
    wr(0, 32'h7F);
    wr(1, 32'h02);
    sci_en = 0;
    ev(6'h02);
    @(negedge clk);
    chk("R2 global sci", {31'b0, sci}, 32'h1);
    wr(0, 32'h7F);

    // R3 sleep: non-waking sources
    sci_en = 1;
    wr(1, 32'h13);
    step(); sleeping = 1;
    ev(6'h3B);
    idle(3);
    rchk(0, 32'h3B, "R3 no wake from tmr/glb/dis-pcie/usb");
    chk("R3 sci held low asleep", {31'b0, sci}, 32'h0);
    chk("R4 go_on low", {31'b0, go_on}, 32'h0);
    wr(1, 32'h1B);
    rchk(0, 32'h7B, "R3 rtc wake");
    chk("R4 go_on high", {31'b0, go_on}, 32'h1);
    step(); sleeping = 0; @(negedge clk);
    chk("R3 sci after wake", {31'b0, sci}, 32'h1);
    wr(0, 32'h7F);
    // power button wakes with enable clear
    wr(1, 32'h00);
    step(); sleeping = 1;
    ev(6'h04);
    idle(1);
    rchk(0, 32'h44, "R3 pwrbtn always wakes");
    step(); sleeping = 0;
    wr(0, 32'h7F);

    // R9 power return
    step(); after_loss_wake = 0; pwr_return = 1;
    step();
    rchk(0, 32'h0, "R9 no wake with option 0");
    step(); after_loss_wake = 1; pwr_return = 1;
    step();
    rchk(0, 32'h40, "R9 wake with option 1");
    wr(0, 32'h7F);

    // R8 clears of rtc enable
    step(); reg_addr = 1; reg_wdata = 32'h08; reg_we = 1; thermal_trip = 1;
    step();
    rchk(1, 32'h0, "R8 thermal beats write");
    wr(1, 32'h08);
    step(); pwrbtn_override = 1;
    step();
    rchk(1, 32'h0, "R8 override clears");

    // R10 reset domains
    wr(1, 32'h3F);
    ev(6'h3F);
    step(); rst_plat_n = 0; idle(2); rst_plat_n = 1; idle(4);
    rchk(0, 32'h3C, "R10 plat status");
    rchk(1, 32'h3C, "R10 plat controls");
    step(); rst_rtc_n = 0; idle(2); rst_rtc_n = 1; idle(4);
    rchk(0, 32'h34, "R10 rtc status");
    rchk(1, 32'h34, "R10 rtc controls");
    step(); rst_resume_n = 0; idle(2); rst_resume_n = 1; idle(4);
    rchk(0, 32'h0, "R10 resume status");
    rchk(1, 32'h0, "R10 resume controls");

    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule